// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one logic cell of a programmable fabric. It holds two 4-input truth tables (called F and G here) and one 3-input combining table (H). H takes the F result, the G result and one direct cell input, so the cell can form any 5-input function, or two independent 4-input functions together with a 3-input function of those two results. The cell also has two output flip-flops and a 2-bit add slice with a dedicated carry path to its neighbour.

All table contents and mode bits sit in one configuration shift chain. The chain is filled serially from external non-volatile storage at start-up. The chain's far end is brought out so that the next cell can be loaded in a daisy chain.

Two of the four modes reuse the F and G tables as user RAM. One mode treats them as a 16x2 memory with separate read addresses. Another treats them as a 32x1 memory. Writes are synchronous. Reads are asynchronous and go through the same lookup path.

A small controller with three states gates the cell. The states are:
- `CFG_EMPTY`: the state after reset.
- `CFG_SHIFT`: the chain is being loaded.
- `CFG_READY`: the cell is active.

The transitions are:
- EMPTY→SHIFT: `cfg_en` is high.
- EMPTY→EMPTY: `cfg_en` is low.
- SHIFT→READY: `cfg_en` falls.
- SHIFT→SHIFT: `cfg_en` stays high.
- READY→SHIFT: a reload starts.
- Any state→EMPTY: synchronous `rst`.

Top module: `clc_cell`

## Requirements
- R1: A synchronous `rst` clears `xq` and `yq` to 0 and returns the controller to CFG_EMPTY, so every logic output reads 0 until a new load.
- R2: While `cfg_en` is high, one bit of `cfg_in` enters the chain on every clock. The 44-bit image is sent in this order: F[15] down to F[0], then G[15..0], then H[7..0], then mode[1], mode[0], xsel, ysel. `cfg_out` always shows the stored F[15], which is the bit shifted in 44 clocks earlier.
- R3: Outside CFG_READY, `x_out`, `y_out`, `z_out`, `carry_out`, and the values captured by `xq` and `yq`, are all 0. The cell becomes active on the first clock at which `cfg_en` is low after a load.
- R4: In logic mode (mode 00), the outputs are:
  - `x_out` = F[`f_in`]
  - `y_out` = G[`g_in`]
  - `z_out` = H[{`h_in`,`y_out`,`x_out`}]
- R5: In wide-RAM mode (mode 10), the outputs are:
  - `x_out` = F[`f_in`]
  - `y_out` = G[`f_in`]; `g_in` is ignored.
  - `z_out` = `h_in` ? `y_out` : `x_out`
- R6: In dual-RAM mode (mode 01), a clock with `wr_en` high writes `wr_data[0]` to F[`wr_addr[3:0]`] and `wr_data[1]` to G[`wr_addr[3:0]`]. Reads follow R4's lookup, and the written value appears after that clock edge.
- R7: In wide-RAM mode, a clock with `wr_en` high writes `wr_data[0]` to one table at `wr_addr[3:0]`. The table is G when `wr_addr[4]`=1 and F when it is 0.
- R8: In logic mode and in add mode, `wr_en` leaves the tables unchanged.
- R9: In add mode (mode 11), the cell adds a0=`f_in[0]`, b0=`f_in[1]`, a1=`g_in[0]`, b1=`g_in[1]` and `carry_in`. `x_out` is sum bit 0, `y_out` is sum bit 1, `carry_out` is the carry out of bit 1, and `z_out` follows R4's H lookup.
- R10: `carry_out` is 0 in every mode other than add mode.
- R11: On each clock, `xq` takes `z_out` when xsel=1 and `x_out` otherwise. `yq` takes `z_out` when ysel=1 and `y_out` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of controller and flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Chain end, for the next cell in the daisy chain |
| f_in | input | 4 | F lookup address / add operands bit 0 |
| g_in | input | 4 | G lookup address / add operands bit 1 |
| h_in | input | 1 | Direct input to the combining table |
| wr_en | input | 1 | RAM write enable |
| wr_addr | input | 5 | RAM write address (bit 4 picks the table in wide mode) |
| wr_data | input | 2 | RAM write data |
| carry_in | input | 1 | Carry from the neighbouring cell |
| carry_out | output | 1 | Carry to the neighbouring cell |
| x_out | output | 1 | F-side result |
| y_out | output | 1 | G-side result |
| z_out | output | 1 | Combining-table result |
| xq | output | 1 | Registered X-side output |
| yq | output | 1 | Registered Y-side output |

## Verification
The tests cover each mode's main function as follows:
- **Logic mode.** F is loaded as a 4-input parity table, G as an asymmetric table, and H as a multiplexer. Addresses are swept so that a wrong bit order in the chain or in the H index changes the result.
- **RAM modes.** The bench writes a value that differs from the stored one and reads the same address on that clock and the clock after. This separates an asynchronous read from a registered write. In dual-RAM mode, F and G are read at different addresses in the same cycle. In wide-RAM mode, some cases tie `g_in` away from `f_in`, which exposes a G read that uses the wrong address.
- **Add mode.** All 32 combinations of the two operand pairs and the incoming carry are applied.
- **Ignored writes.** Write attempts in logic and add modes are checked through later lookups and through `cfg_out`.

// File: rtl/clc_pkg.sv
package clc_pkg;

    localparam int H_K      = 3;  // combining table inputs: F, G, direct input
    localparam int SUM_BITS = 2;  // add slice width, one bit per 4-input table
    localparam int MODE_W   = 4;  // mode[1:0], xsel, ysel

    typedef enum logic [1:0] {
        MODE_LOGIC    = 2'b00,
        MODE_RAM_DUAL = 2'b01,
        MODE_RAM_WIDE = 2'b10,
        MODE_ADD      = 2'b11
    } cell_mode_e;

    typedef enum logic [1:0] {
        CFG_EMPTY = 2'b00,
        CFG_SHIFT = 2'b01,
        CFG_READY = 2'b10
    } cfg_state_e;

endpackage

// File: rtl/clc_cfg_fsm.sv
module clc_cfg_fsm
    import clc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    output logic active
);

    cfg_state_e state_q;
    cfg_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CFG_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        active  = 1'b0;
        unique case (state_q)
            CFG_EMPTY: begin
                if (cfg_en) state_d = CFG_SHIFT;
            end
            CFG_SHIFT: begin
                if (!cfg_en) state_d = CFG_READY;
            end
            CFG_READY: begin
                active = 1'b1;
                if (cfg_en) state_d = CFG_SHIFT;
            end
            default: begin
                state_d = CFG_EMPTY;
            end
        endcase
    end

endmodule

// File: rtl/clc_lut.sv
module clc_lut #(
    parameter int IN = 4
) (
    input  logic [(1 << IN)-1:0] table_bits,
    input  logic [IN-1:0]        sel,
    output logic                 dout
);

    localparam int DEPTH = 1 << IN;

    // Binary mux tree, one level per select bit.
    logic [DEPTH-1:0] lvl [IN+1];

    assign lvl[0] = table_bits;

    for (genvar s = 0; s < IN; s++) begin : g_level
        localparam int W = DEPTH >> (s + 1);
        for (genvar k = 0; k < W; k++) begin : g_node
            assign lvl[s+1][k] = sel[s] ? lvl[s][2*k+1] : lvl[s][2*k];
        end
        if (W < DEPTH) begin : g_pad
            assign lvl[s+1][DEPTH-1:W] = '0;
        end
    end

    assign dout = lvl[IN][0];

endmodule

// File: rtl/clc_carry.sv
module clc_carry #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < N; i++) begin
            sum[i] = a[i] ^ b[i] ^ c;
            c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        cout = c;
    end

endmodule

// File: rtl/clc_cell.sv
module clc_cell
    import clc_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    input  logic             wr_en,
    input  logic [LUT_K:0]   wr_addr,
    input  logic [1:0]       wr_data,
    input  logic             carry_in,
    output logic             carry_out,
    output logic             x_out,
    output logic             y_out,
    output logic             z_out,
    output logic             xq,
    output logic             yq
);

    localparam int FG_N    = 1 << LUT_K;
    localparam int H_N     = 1 << H_K;
    localparam int CFG_LEN = 2 * FG_N + H_N + MODE_W;
    localparam int YSEL_B  = 0;
    localparam int XSEL_B  = 1;
    localparam int MODE_LO = 2;
    localparam int H_LO    = MODE_W;
    localparam int G_LO    = H_LO + H_N;
    localparam int F_LO    = G_LO + FG_N;
    localparam int IDX_W   = $clog2(CFG_LEN);

    // Configuration chain: tables and mode bits, shifted MSB first.
    logic [CFG_LEN-1:0] cfg_sr;
    logic               active;
    cell_mode_e         mode;
    logic               x_sel;
    logic               y_sel;

    assign mode    = cell_mode_e'(cfg_sr[MODE_LO +: 2]);
    assign x_sel   = cfg_sr[XSEL_B];
    assign y_sel   = cfg_sr[YSEL_B];
    assign cfg_out = cfg_sr[CFG_LEN-1];

    clc_cfg_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .active (active)
    );

    // Write addresses inside the chain for the two RAM modes.
    logic [IDX_W-1:0] f_wr_idx;
    logic [IDX_W-1:0] g_wr_idx;

    assign f_wr_idx = IDX_W'(F_LO) + IDX_W'(wr_addr[LUT_K-1:0]);
    assign g_wr_idx = IDX_W'(G_LO) + IDX_W'(wr_addr[LUT_K-1:0]);

    always_ff @(posedge clk) begin
        if (cfg_en) begin
            cfg_sr <= {cfg_sr[CFG_LEN-2:0], cfg_in};
        end else if (active && wr_en) begin
            case (mode)
                MODE_RAM_DUAL: begin
                    cfg_sr[f_wr_idx] <= wr_data[0];
                    cfg_sr[g_wr_idx] <= wr_data[1];
                end
                MODE_RAM_WIDE: begin
                    if (wr_addr[LUT_K]) begin
                        cfg_sr[g_wr_idx] <= wr_data[0];
                    end else begin
                        cfg_sr[f_wr_idx] <= wr_data[0];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Lookup path.
    logic [LUT_K-1:0] g_addr;
    logic             f_lut;
    logic             g_lut;
    logic             h_lut;

    assign g_addr = (mode == MODE_RAM_WIDE) ? f_in : g_in;

    clc_lut #(.IN(LUT_K)) u_f (
        .table_bits (cfg_sr[F_LO +: FG_N]),
        .sel        (f_in),
        .dout       (f_lut)
    );

    clc_lut #(.IN(LUT_K)) u_g (
        .table_bits (cfg_sr[G_LO +: FG_N]),
        .sel        (g_addr),
        .dout       (g_lut)
    );

    // Add slice.
    logic [SUM_BITS-1:0] add_sum;
    logic                add_co;

    clc_carry #(.N(SUM_BITS)) u_add (
        .a    ({g_in[0], f_in[0]}),
        .b    ({g_in[1], f_in[1]}),
        .cin  (carry_in),
        .sum  (add_sum),
        .cout (add_co)
    );

    logic x_raw;
    logic y_raw;
    logic z_raw;
    logic co_raw;

    assign x_raw = (mode == MODE_ADD) ? add_sum[0] : f_lut;
    assign y_raw = (mode == MODE_ADD) ? add_sum[1] : g_lut;

    clc_lut #(.IN(H_K)) u_h (
        .table_bits (cfg_sr[H_LO +: H_N]),
        .sel        ({h_in, y_raw, x_raw}),
        .dout       (h_lut)
    );

    assign z_raw  = (mode == MODE_RAM_WIDE) ? (h_in ? y_raw : x_raw) : h_lut;
    assign co_raw = (mode == MODE_ADD) ? add_co : 1'b0;

    assign x_out     = active & x_raw;
    assign y_out     = active & y_raw;
    assign z_out     = active & z_raw;
    assign carry_out = active & co_raw;

    // Output flip-flops.
    always_ff @(posedge clk) begin
        if (rst) begin
            xq <= 1'b0;
            yq <= 1'b0;
        end else begin
            xq <= x_sel ? z_out : x_out;
            yq <= y_sel ? z_out : y_out;
        end
    end

endmodule

// File: rtl/clc_cell_chk.sv
module clc_cell_chk #(
    parameter int LUT_K = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             wr_en,
    input logic             active,
    input logic [1:0]       mode,
    input logic             x_sel,
    input logic             y_sel,
    input logic [LUT_K-1:0] f_in,
    input logic             carry_in,
    input logic             cfg_out,
    input logic             x_out,
    input logic             y_out,
    input logic             z_out,
    input logic             carry_out,
    input logic             xq,
    input logic             yq
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!xq && !yq));

    assert_quiet_inactive_R3: assert property (@(posedge clk) disable iff (rst)
        !active |-> !(x_out || y_out || z_out || carry_out));

    assert_load_suspends_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> !active);

    assert_tables_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !$isunknown(cfg_out)
         && !(active && wr_en && (mode == 2'b01 || mode == 2'b10)))
        |=> $stable(cfg_out));

    assert_sum_bit0_R9: assert property (@(posedge clk) disable iff (rst)
        (active && mode == 2'b11) |-> (x_out == (f_in[0] ^ f_in[1] ^ carry_in)));

    assert_carry_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b11) |-> !carry_out);

    assert_xq_capture_R11: assert property (@(posedge clk) disable iff (rst)
        active |=> (xq == $past(x_sel ? z_out : x_out)));

    assert_yq_capture_R11: assert property (@(posedge clk) disable iff (rst)
        active |=> (yq == $past(y_sel ? z_out : y_out)));

endmodule

bind clc_cell clc_cell_chk #(.LUT_K(LUT_K)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .wr_en     (wr_en),
    .active    (active),
    .mode      (mode),
    .x_sel     (x_sel),
    .y_sel     (y_sel),
    .f_in      (f_in),
    .carry_in  (carry_in),
    .cfg_out   (cfg_out),
    .x_out     (x_out),
    .y_out     (y_out),
    .z_out     (z_out),
    .carry_out (carry_out),
    .xq        (xq),
    .yq        (yq)
);

// File: tb/tb_clc_cell.sv
module tb_clc_cell;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic       h_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic       carry_in = 1'b0;
    logic       cfg_out, carry_out, x_out, y_out, z_out, xq, yq;

    always #(CLK_PERIOD/2) clk = ~clk;

    clc_cell dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
        .f_in(f_in), .g_in(g_in), .h_in(h_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .carry_in(carry_in), .carry_out(carry_out),
        .x_out(x_out), .y_out(y_out), .z_out(z_out), .xq(xq), .yq(yq)
    );

    // Reference model, written from the requirements.
    logic [43:0] mSr;
    int          mSt = 0;      // 0 empty, 1 shifting, 2 ready
    logic        mXq = 1'b0;
    logic        mYq = 1'b0;

    typedef struct {
        string      tag;
        logic [6:0] exp;       // {cfg_out, yq, xq, carry_out, z, y, x}
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t mon_item;
    event     sample_ev;
    int       n_vec = 0;
    int       n_bad = 0;
    bit       done = 0;

    function automatic logic [3:0] model_comb();
        logic [15:0] tf, tg;
        logic [7:0]  th;
        logic        x, y, z, co, c1;
        if (mSt != 2) return 4'b0;
        tf = mSr[43:28]; tg = mSr[27:12]; th = mSr[11:4];
        co = 1'b0;
        case (mSr[3:2])
            2'b11: begin
                c1 = (f_in[0] & f_in[1]) | (carry_in & (f_in[0] ^ f_in[1]));
                x  = f_in[0] ^ f_in[1] ^ carry_in;
                y  = g_in[0] ^ g_in[1] ^ c1;
                co = (g_in[0] & g_in[1]) | (c1 & (g_in[0] ^ g_in[1]));
                z  = th[{h_in, y, x}];
            end
            2'b10: begin
                x = tf[f_in];
                y = tg[f_in];
                z = h_in ? y : x;
            end
            default: begin
                x = tf[f_in];
                y = tg[g_in];
                z = th[{h_in, y, x}];
            end
        endcase
        return {co, z, y, x};
    endfunction

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                logic [6:0] act;
                bit         bad;
                mon_item = sb_q.pop_front();
                act = {cfg_out, yq, xq, carry_out, z_out, y_out, x_out};
                n_vec++;
                if (mon_item.exp[6] === 1'bx) bad = (act[5:0] !== mon_item.exp[5:0]);
                else                          bad = (act !== mon_item.exp);
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: {cfg_out,yq,xq,co,z,y,x} got %b expected %b",
                             mon_item.tag, act, mon_item.exp);
                end
            end
        end
    end

    // Driver side: push the expected item for the current inputs.
    task automatic check(input string tag);
        sb_item_t it;
        #1;
        it.tag = tag;
        it.exp = {mSr[43], mYq, mXq, model_comb()};
        sb_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic tick();
        logic [3:0] c;
        int         st_old;
        c = model_comb();
        st_old = mSt;
        @(posedge clk);
        if (rst) begin
            mSt = 0; mXq = 1'b0; mYq = 1'b0;
        end else begin
            mXq = mSr[1] ? c[2] : c[0];
            mYq = mSr[0] ? c[2] : c[1];
            mSt = cfg_en ? 1 : ((st_old == 0) ? 0 : 2);
        end
        if (cfg_en) begin
            mSr = {mSr[42:0], cfg_in};
        end else if (st_old == 2 && wr_en) begin
            if (mSr[3:2] == 2'b01) begin
                mSr[28 + int'(wr_addr[3:0])] = wr_data[0];
                mSr[12 + int'(wr_addr[3:0])] = wr_data[1];
            end else if (mSr[3:2] == 2'b10) begin
                if (wr_addr[4]) mSr[12 + int'(wr_addr[3:0])] = wr_data[0];
                else            mSr[28 + int'(wr_addr[3:0])] = wr_data[0];
            end
        end
        @(negedge clk);
    endtask

    task automatic vec(input logic [3:0] f, input logic [3:0] g, input logic h,
                       input logic ci, input string tag);
        f_in = f; g_in = g; h_in = h; carry_in = ci;
        check(tag);
        tick();
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        check(tag);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] tf, input logic [15:0] tg, input logic [7:0] th,
                        input logic [1:0] md, input logic xs, input logic ys);
        logic [43:0] img;
        img = {tf, tg, th, md, xs, ys};
        for (int i = 43; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_in = img[i];
            if (i % 11 == 3) check("R2 R3 load");
            tick();
        end
        cfg_en = 1'b0;
        check("R3 load end");
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        vec(4'h0, 4'h0, 1'b0, 1'b0, "R1 reset");
        vec(4'hF, 4'hF, 1'b1, 1'b1, "R1 reset");
        rst = 1'b0;
        // R3: unconfigured cell stays quiet
        vec(4'h5, 4'hA, 1'b1, 1'b1, "R3 empty");
        vec(4'hF, 4'h3, 1'b0, 1'b1, "R3 empty");

        // Logic mode: F parity (xnor), G asymmetric, H mux, xq<-z, yq<-y
        load(16'h9669, 16'h8001, 8'hCA, 2'b00, 1'b1, 1'b0);
        vec(4'h0, 4'hF, 1'b0, 1'b1, "R2 R4 R10");
        vec(4'h1, 4'hF, 1'b1, 1'b1, "R4 R10 R11");
        vec(4'h7, 4'h0, 1'b1, 1'b0, "R4 R11");
        vec(4'hC, 4'h1, 1'b0, 1'b1, "R4 R11");
        vec(4'h8, 4'h7, 1'b1, 1'b0, "R4 R10 R11");
        vec(4'h3, 4'h2, 1'b0, 1'b0, "R4 R11");
        // R8: write in logic mode is ignored
        wr(5'd2, 2'b11, "R8 logic write");
        vec(4'h2, 4'h2, 1'b0, 1'b0, "R8 logic read back");

        // Dual RAM mode
        load(16'h8000, 16'h0000, 8'hE8, 2'b01, 1'b0, 1'b1);
        vec(4'h5, 4'h5, 1'b0, 1'b0, "R2 R6 before write");
        wr(5'd5, 2'b11, "R6 write same cycle");
        vec(4'h5, 4'h5, 1'b1, 1'b0, "R6 after write");
        wr(5'd15, 2'b10, "R6 write F15");
        vec(4'hF, 4'hF, 1'b0, 1'b0, "R2 R6 cfg_out follows F15");
        vec(4'h5, 4'hF, 1'b0, 1'b0, "R6 split read ports");
        vec(4'hF, 4'h5, 1'b1, 1'b1, "R6 R10 split read ports");

        // Wide RAM mode
        load(16'h00FF, 16'hF00F, 8'h00, 2'b10, 1'b1, 1'b1);
        wr(5'h13, 2'b00, "R7 write G3");
        wr(5'h0A, 2'b01, "R7 write F10");
        vec(4'h3, 4'h0, 1'b1, 1'b0, "R5 R7 read G3");
        vec(4'hA, 4'h0, 1'b0, 1'b0, "R5 R7 read F10");
        vec(4'hC, 4'h3, 1'b1, 1'b0, "R5 g_in ignored");
        vec(4'h3, 4'hC, 1'b0, 1'b1, "R5 R10 R11");

        // Add mode: all operand and carry combinations
        load(16'h0000, 16'h0000, 8'h96, 2'b11, 1'b1, 1'b0);
        for (int k = 0; k < 32; k++) begin
            logic [4:0] kv;
            kv = 5'(k);
            vec({2'b00, kv[1:0]}, {2'b00, kv[3:2]}, kv[1], kv[4], "R9 R11 add");
        end
        wr(5'd15, 2'b11, "R8 add write");
        vec(4'h3, 4'h3, 1'b0, 1'b1, "R8 R9 table unchanged");

        // R1: reset while active
        rst = 1'b1;
        vec(4'h3, 4'h3, 1'b1, 1'b1, "R1 reset active");
        vec(4'h1, 4'h2, 1'b0, 1'b1, "R1 reset held");
        rst = 1'b0;
        vec(4'h3, 4'h3, 1'b1, 1'b1, "R3 after reset");
        vec(4'h0, 4'h0, 1'b0, 1'b0, "R3 after reset");

        #(CLK_PERIOD);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule